// File: doc/BRIEF.md
# Memory-Operand Widening Converter

This block takes one operand as it arrives from memory and rewrites it in the 80-bit internal number form. The operand can be a short or long binary floating-point value or a signed two's-complement integer of 16, 32 or 64 bits. The 80-bit result holds a sign, a 15-bit exponent biased by 16383, and a 64-bit significand. In that significand the integer bit is stored explicitly in bit 63.

Floating-point sources have their hidden leading one restored and their exponent moved onto the wider bias. Denormal sources are shifted until their leading one reaches bit 63, because the wide exponent can represent them as normal numbers. Zero, infinity and NaN sources are recognised and mapped to their wide forms. Integer sources are first turned into sign and magnitude. The magnitude is then normalised by the same leading-zero shifter that serves the denormals.

The result is captured in an output register when the input strobe is high. A build option can remove this register and give a purely combinational path.

Top module: `fpx_widen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is 0 and out_value is all zeros.
- R2: out_valid equals in_valid delayed by one clock. out_value loads only in a cycle where in_valid is high and holds its value otherwise.
- R3: The in_fmt codes are: 0 = 32-bit float taken from in_data[31:0]; 1 = 64-bit float taken from in_data[63:0]; 2 = int16 taken from [15:0]; 3 = int32 taken from [31:0]; 4 = int64. Operand bits above the selected width have no effect. Codes 5 to 7 produce +0. out_value packs the sign in [79], the exponent in [78:64] and the significand in [63:0].
- R4: A normal float keeps its sign. Its exponent becomes the stored exponent minus the source bias (127 or 1023) plus 16383. Its significand has bit 63 set, with the fraction left-aligned directly below it.
- R5: A float with zero exponent and zero fraction gives exponent 0 and significand 0, with the sign kept.
- R6: A float with an all-ones exponent and a zero fraction gives exponent 0x7FFF and significand 0x8000_0000_0000_0000, with the sign kept.
- R7: A float with an all-ones exponent and a nonzero fraction gives exponent 0x7FFF, bit 63 set, and the fraction left-aligned from bit 62 down.
- R8: A denormal float is normalised. Its fraction is placed from bit 62 down and then shifted left by n places until the leading one reaches bit 63. The exponent is 16384 minus the source bias minus n.
- R9: A nonzero integer gives sign = its top bit. The magnitude is shifted left by s places to put its leading one at bit 63, and the exponent is 16446 - s. An integer zero gives all zeros (+0).
- R10: The most negative int64 (0x8000_0000_0000_0000) converts exactly to sign 1, exponent 0x403E, significand 0x8000_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_fmt | input | 3 | Source format code |
| in_data | input | 64 | Operand bits, right-aligned |
| out_valid | output | 1 | Result strobe |
| out_value | output | 80 | Widened result: sign, exponent, significand |

## Verification
The hardest cases to reach from the ports are the denormals and the extreme integers. With uniform random operands a float almost never has an all-zero exponent, and an integer almost never has a long run of leading zeros or equals the most negative value. These are exactly the cases that exercise the deepest shifts of the normaliser. The stimulus therefore picks a class before it picks bits. It forces the exponent field to zero or to all ones, masks integers down to a few random low bits, and mixes these with directed values such as the smallest denormal and -2^63. A behavioural reference in the bench normalises by repeated single-bit shifts and checks each of these results.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int XEXP_W = 15;
   localparam int XSIG_W = 64;
   localparam int XBIAS  = 16383;
   localparam int OPD_W  = 64;
   localparam int BASE_W = 17;
   localparam int RES_W  = 1 + XEXP_W + XSIG_W;

   typedef enum logic [2:0] {
      FMT_SGL = 3'd0,
      FMT_DBL = 3'd1,
      FMT_I16 = 3'd2,
      FMT_I32 = 3'd3,
      FMT_I64 = 3'd4
   } fmt_e;

   // common unpacked operand: magnitude placed with its integer bit at the top
   typedef struct packed {
      logic                sign;
      logic                special;
      logic [XSIG_W-1:0]   mag;
      logic [BASE_W-1:0]   base;
   } unpk_t;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
   parameter int W  = 64,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) cnt = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/fpx_fp_split.sv
module fpx_fp_split
   import fpx_pkg::*;
#(
   parameter int EW   = 8,
   parameter int FW   = 23,
   parameter int BIAS = 127
) (
   input  logic [EW+FW:0] bits,
   output unpk_t          u
);
   localparam int ADJ  = XBIAS - BIAS;
   localparam int PADW = XSIG_W - 1 - FW;

   if (PADW < 0) begin : g_bad_fw
      $error("fraction wider than significand");
   end

   logic [EW-1:0] e;
   logic [FW-1:0] f;

   always_comb begin
      e         = bits[EW+FW-1:FW];
      f         = bits[FW-1:0];
      u.sign    = bits[EW+FW];
      u.special = &e;
      u.mag     = {(|e), f, {PADW{1'b0}}};
      u.base    = (|e) ? BASE_W'(ADJ) + BASE_W'(e) : BASE_W'(ADJ + 1);
   end
endmodule

// File: rtl/fpx_int_split.sv
module fpx_int_split
   import fpx_pkg::*;
(
   input  logic [OPD_W-1:0] v,
   output unpk_t            u
);
   always_comb begin
      u.sign    = v[OPD_W-1];
      u.special = 1'b0;
      u.mag     = v[OPD_W-1] ? (~v + 64'd1) : v;
      u.base    = BASE_W'(XBIAS + XSIG_W - 1);
   end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen
   import fpx_pkg::*;
#(
   parameter bit REG_OUT = 1'b1,
   parameter int EXP_W   = 15,
   parameter int SIG_W   = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [2:0]               in_fmt,
   input  logic [OPD_W-1:0]         in_data,
   output logic                     out_valid,
   output logic [EXP_W+SIG_W:0]     out_value
);
   localparam int LZ_W = $clog2(SIG_W + 1);

   if (EXP_W != XEXP_W || SIG_W != XSIG_W) begin : g_bad_shape
      $error("result shape must be 15-bit exponent, 64-bit significand");
   end

   unpk_t fp_u [2];
   unpk_t int_u;
   unpk_t sel;
   logic [OPD_W-1:0] ext;
   logic [LZ_W-1:0]  lz;
   logic [EXP_W+SIG_W:0] res;

   // one float field splitter per source precision
   for (genvar g = 0; g < 2; g++) begin : g_fp
      localparam int EW = (g == 0) ? 8 : 11;
      localparam int FW = (g == 0) ? 23 : 52;
      localparam int BS = (g == 0) ? 127 : 1023;
      fpx_fp_split #(.EW(EW), .FW(FW), .BIAS(BS)) u_split (
         .bits (in_data[EW+FW:0]),
         .u    (fp_u[g])
      );
   end

   always_comb begin
      case (in_fmt)
         FMT_I16: ext = {{48{in_data[15]}}, in_data[15:0]};
         FMT_I32: ext = {{32{in_data[31]}}, in_data[31:0]};
         default: ext = in_data;
      endcase
   end

   fpx_int_split u_int (.v(ext), .u(int_u));

   always_comb begin
      case (in_fmt)
         FMT_SGL:                   sel = fp_u[0];
         FMT_DBL:                   sel = fp_u[1];
         FMT_I16, FMT_I32, FMT_I64: sel = int_u;
         default:                   sel = '0;
      endcase
   end

   fpx_lzc #(.W(SIG_W)) u_lzc (.vec(sel.mag), .cnt(lz));

   always_comb begin
      res[EXP_W+SIG_W] = sel.sign;
      if (sel.special) begin
         res[EXP_W+SIG_W-1:SIG_W] = '1;
         res[SIG_W-1:0]           = sel.mag;
      end else if (sel.mag == '0) begin
         res[EXP_W+SIG_W-1:0] = '0;
      end else begin
         res[EXP_W+SIG_W-1:SIG_W] = EXP_W'(sel.base - BASE_W'(lz));
         res[SIG_W-1:0]           = sel.mag << lz;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) out_value <= res;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_value = res;
   end
endmodule

// File: rtl/fpx_widen_chk.sv
module fpx_widen_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [2:0]  in_fmt,
   input logic [63:0] in_data,
   input logic        out_valid,
   input logic [79:0] out_value
);
   // R5
   zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_value[78:64] == 15'd0) |-> (out_value[63:0] == 64'd0));

   // R8
   norm_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_value[78:64] != 15'd0) |-> out_value[63]);

   if (REG_OUT) begin : g_timed
      // R1
      reset_clear_chk: assert property (@(posedge clk)
         !rst_n |=> (!out_valid && out_value == 80'd0));

      // R2
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R2
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(out_value)));

      // R3
      unused_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_fmt > 3'd4) |=> (out_value == 80'd0));

      // R9
      int_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_fmt == 3'd4 && in_data == 64'd0) |=> (out_value == 80'd0));
   end
endmodule

bind fpx_widen fpx_widen_chk #(.REG_OUT(REG_OUT)) u_fpx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_fmt    (in_fmt),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_value (out_value)
);

// File: tb/test_fpx_widen.sv
`timescale 1ns/1ps
module test_fpx_widen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_fmt = 3'd0;
   logic [63:0] in_data = 64'd0;
   logic        out_valid;
   logic [79:0] out_value;

   int compared = 0;
   int mismatched = 0;
   bit running = 1'b0;
   bit finished = 1'b0;

   logic        mdl_v;
   logic [79:0] mdl_val;
   string       mdl_tag;

   always #10 clk = ~clk;

   fpx_widen i_fpx_widen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
      .in_data(in_data), .out_valid(out_valid), .out_value(out_value)
   );

   function automatic logic [79:0] ref_widen(input logic [2:0] fmt, input logic [63:0] d);
      logic s;
      int e, emax, bias, fw, ex;
      logic [63:0] f, sig, v;
      if (fmt == 3'd0 || fmt == 3'd1) begin
         if (fmt == 3'd0) begin
            s = d[31]; e = int'(d[30:23]); f = {41'd0, d[22:0]}; fw = 23; emax = 255; bias = 127;
         end else begin
            s = d[63]; e = int'(d[62:52]); f = {12'd0, d[51:0]}; fw = 52; emax = 2047; bias = 1023;
         end
         if (e == emax) return {s, 15'h7FFF, 64'h8000_0000_0000_0000 | (f << (63 - fw))};
         if (e == 0 && f == 64'd0) return {s, 79'd0};
         if (e == 0) begin
            sig = f << (63 - fw); ex = 16384 - bias;
         end else begin
            sig = 64'h8000_0000_0000_0000 | (f << (63 - fw)); ex = e - bias + 16383;
         end
      end else if (fmt <= 3'd4) begin
         if (fmt == 3'd2) v = {{48{d[15]}}, d[15:0]};
         else if (fmt == 3'd3) v = {{32{d[31]}}, d[31:0]};
         else v = d;
         if (v == 64'd0) return 80'd0;
         s = v[63];
         sig = s ? (~v + 64'd1) : v;
         ex = 16446;
      end else begin
         return 80'd0;
      end
      while (!sig[63]) begin
         sig = sig << 1;
         ex = ex - 1;
      end
      return {s, 15'(ex), sig};
   endfunction

   function automatic string tag_of(input logic [2:0] fmt, input logic [63:0] d);
      logic [10:0] e;
      logic nzf;
      if (fmt > 3'd4) return "R3";
      if (fmt >= 3'd2) return (fmt == 3'd4 && d == 64'h8000_0000_0000_0000) ? "R10" : "R9";
      e   = (fmt == 3'd0) ? {3'd0, d[30:23]} : d[62:52];
      nzf = (fmt == 3'd0) ? (d[22:0] != 0) : (d[51:0] != 0);
      if (e == ((fmt == 3'd0) ? 11'd255 : 11'd2047)) return nzf ? "R7" : "R6";
      if (e == 0) return nzf ? "R8" : "R5";
      return "R4";
   endfunction

   task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // behavioural model of the registered result
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdl_v   <= 1'b0;
         mdl_val <= 80'd0;
         mdl_tag <= "R1";
      end else begin
         mdl_v <= in_valid;
         if (in_valid) begin
            mdl_val <= ref_widen(in_fmt, in_data);
            mdl_tag <= tag_of(in_fmt, in_data);
         end
      end
   end

   // compare against the model on every clock (R2 for the strobe)
   always @(negedge clk) begin
      if (running) begin
         check("R2", {79'd0, out_valid}, {79'd0, mdl_v});
         check(mdl_tag, out_value, mdl_val);
      end
   end

   task automatic run1(input logic [2:0] fmt, input logic [63:0] d,
                       input logic [79:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_fmt = fmt; in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, out_value, exp);
   endtask

   initial begin
      #(20ns * 100000);
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {out_value[79:1], out_valid}, 80'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {out_value[79:1], out_valid}, 80'd0);
      running = 1'b1;

      run1(3'd0, 64'h0000_0000_3F80_0000, 80'h3FFF_8000_0000_0000_0000, "R4");
      run1(3'd1, 64'hC000_0000_0000_0000, 80'hC000_8000_0000_0000_0000, "R4");
      run1(3'd0, 64'h0000_0000_8000_0000, 80'h8000_0000_0000_0000_0000, "R5");
      run1(3'd0, 64'h0000_0000_7F80_0000, 80'h7FFF_8000_0000_0000_0000, "R6");
      run1(3'd0, 64'h0000_0000_7FC0_0001, 80'h7FFF_C000_0100_0000_0000, "R7");
      run1(3'd0, 64'h0000_0000_0000_0001, 80'h3F6A_8000_0000_0000_0000, "R8");
      run1(3'd1, 64'h0000_0000_0000_0001, 80'h3BCD_8000_0000_0000_0000, "R8");
      run1(3'd2, 64'h0000_0000_0000_FFFF, 80'hBFFF_8000_0000_0000_0000, "R9");
      run1(3'd2, 64'hABCD_0000_0000_0005, 80'h4001_A000_0000_0000_0000, "R3");
      run1(3'd3, 64'hFFFF_FFFF_0000_0000, 80'h0000_0000_0000_0000_0000, "R9");
      run1(3'd4, 64'h8000_0000_0000_0000, 80'hC03E_8000_0000_0000_0000, "R10");
      run1(3'd6, 64'h1234_5678_9ABC_DEF0, 80'h0000_0000_0000_0000_0000, "R3");
      run1(3'd0, 64'h0000_0000_3F80_0000, 80'h3FFF_8000_0000_0000_0000, "R4");

      // R2: idle input with new data must leave the result untouched
      @(negedge clk);
      in_valid = 1'b0; in_fmt = 3'd1; in_data = 64'h4000_0000_0000_0000;
      @(negedge clk);
      check("R2", out_value, 80'h3FFF_8000_0000_0000_0000);
      check("R2", {79'd0, out_valid}, 80'd0);

      for (int n = 0; n < 4000; n++) begin
         logic [2:0] fmt;
         logic [63:0] d;
         int cls;
         @(negedge clk);
         fmt = 3'($urandom_range(0, 6));
         d   = {$urandom, $urandom};
         cls = $urandom_range(0, 5);
         if (cls == 0) begin
            d[62:52] = 11'h7FF; d[30:23] = 8'hFF;
         end else if (cls == 1) begin
            d[62:52] = 11'h000; d[30:23] = 8'h00;
            if ($urandom_range(0, 1) == 1) d[40:0] = 41'd0;
         end else if (cls == 2) begin
            d = 64'd0;
            if ($urandom_range(0, 1) == 1) d[63] = 1'b1;
            if ($urandom_range(0, 1) == 1) d[31] = 1'b1;
         end else if (cls == 3) begin
            d = 64'($urandom_range(0, 300));
            if ($urandom_range(0, 1) == 1) d = ~d + 64'd1;
         end
         in_valid = ($urandom_range(0, 4) != 0);
         in_fmt = fmt;
         in_data = d;
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      running = 1'b0;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule